// File: doc/BRIEF.md
# Bank-Windowed Configuration Register File

This block holds byte-wide configuration data behind a 7-bit host address. The upper half of the address space is a fixed set of 64 direct registers. The lower half is a 64-byte window onto one of sixteen banks of storage. Which bank shows through the window is set by a bank-select register that lives in the direct area at address 0x40. A single host write to that address therefore changes what all 64 window addresses return.

A serial host front end uses the host port, which is a plain synchronous read/write port. A second port lets a loader fill or dump any bank by absolute bank number and offset, without regard to the bank-select register. This is how contents are brought in from non-volatile storage at start-up, or written back to it. Both ports return read data one cycle after the request.

Top module: `cfgrf_top`

## Requirements
- R1: After synchronous reset, `h_rdata` and `ld_rdata` are 0x00, and every direct register, the bank-select register included, reads 0x00.
- R2: A host read (`h_en`=1, `h_we`=0) returns data on `h_rdata` one cycle later. `h_rdata` holds its value in every cycle without a host read.
- R3: A write to a direct address 0x41–0x7F stores the full byte. Those registers never change with the bank selection or through the loader port, and such a write leaves the bank selection as it was.
- R4: A write to 0x40 keeps only bits 3:0 of the written byte. A read of 0x40 returns that value with bits 7:4 equal to zero (writing 0x3A reads back 0x0A).
- R5: A host access to 0x00–0x3F reaches the cell at offset `h_addr[5:0]` of the bank named by the bank-select register.
- R6: A host access to 0x00–0x3F in the cycle right after a write to 0x40 already uses the newly written bank.
- R7: The loader port reaches the cell at bank `ld_bank` and offset `ld_off`, whatever the bank-select register holds. Loader writes become visible to host reads through the window when the selection matches.
- R8: A loader read (`ld_en`=1, `ld_we`=0) returns data on `ld_rdata` one cycle later. `ld_rdata` holds its value in every cycle without a loader read.
- R9: When the host port and the loader port write the same bank cell in one cycle, the cell keeps the host's byte. Writes by the two ports to different cells in one cycle both take effect.
- R10: A loader read of a cell that the host writes in the same cycle returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_en | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 7 | Host register address |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, one cycle after the read |
| ld_en | input | 1 | Loader access request |
| ld_we | input | 1 | Loader write (1) or read (0) |
| ld_bank | input | 4 | Loader absolute bank number |
| ld_off | input | 6 | Loader offset inside the bank |
| ld_wdata | input | 8 | Loader write byte |
| ld_rdata | output | 8 | Loader read byte, one cycle after the read |

## Verification
The window is tried three ways. The same offset is written with different bytes under different bank selections and then read back after switching, which separates a correct window from one that ignores or lags the selection. Reads issued in the cycle right after a bank-select write tell a same-cycle update apart from a stale bank. Out-of-range select values such as 0xF7 and 0x3A show whether the upper bits are dropped. The loader is exercised with a selection different from its own bank, and with same-cell and same-cycle traffic on both ports, which exposes priority and read-before-write ordering errors.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int BANK_CNT   = 16;
    localparam int BANK_SEL_W = $clog2(BANK_CNT);
    localparam int WIN_W      = ADDR_W - 1;
    localparam int WIN_DEPTH  = 1 << WIN_W;
    localparam int BSEL_IDX   = 0;

    typedef logic [DATA_W-1:0]     byte_t;
    typedef logic [BANK_SEL_W-1:0] bank_t;
    typedef logic [WIN_W-1:0]      off_t;
    typedef logic [ADDR_W-1:0]     addr_t;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_BANK   = 2'd1,
        TGT_DIRECT = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e  tgt;
        logic  wr;
        bank_t bank;
        off_t  off;
        byte_t wdata;
    } acc_t;

    // Keep only the bits that name a valid bank.
    function automatic byte_t bsel_sanitize(byte_t v);
        byte_t mask;
        mask = byte_t'((1 << BANK_SEL_W) - 1);
        return v & mask;
    endfunction
endpackage

// File: rtl/cfgrf_decode.sv
module cfgrf_decode
    import cfgrf_pkg::*;
(
    input  logic  en,
    input  logic  we,
    input  addr_t addr,
    input  byte_t wdata,
    input  bank_t bank_sel,
    output acc_t  acc
);
    always_comb begin
        if (!en)
            acc.tgt = TGT_NONE;
        else if (addr[ADDR_W-1])
            acc.tgt = TGT_DIRECT;
        else
            acc.tgt = TGT_BANK;
        acc.wr    = we;
        acc.bank  = bank_sel;
        acc.off   = addr[WIN_W-1:0];
        acc.wdata = wdata;
    end
endmodule

// File: rtl/cfgrf_direct.sv
module cfgrf_direct
    import cfgrf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  off_t  off,
    input  byte_t wdata,
    output byte_t rd_q,
    output bank_t bank_sel
);
    byte_t regs [WIN_DEPTH];

    for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_reg
        if (i == BSEL_IDX) begin : g_bsel
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (wr_en && off == off_t'(i))
                    regs[i] <= bsel_sanitize(wdata);
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (wr_en && off == off_t'(i))
                    regs[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= regs[off];
    end

    assign bank_sel = regs[BSEL_IDX][BANK_SEL_W-1:0];
endmodule

// File: rtl/cfgrf_bank_store.sv
module cfgrf_bank_store
    import cfgrf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  h_wr,
    input  logic  h_rd,
    input  bank_t h_bank,
    input  off_t  h_off,
    input  byte_t h_wdata,
    input  logic  l_en,
    input  logic  l_we,
    input  bank_t l_bank,
    input  off_t  l_off,
    input  byte_t l_wdata,
    output byte_t h_q,
    output byte_t l_q
);
    localparam int IDX_W = BANK_SEL_W + WIN_W;
    localparam int DEPTH = BANK_CNT * WIN_DEPTH;

    byte_t            mem [DEPTH];
    logic [IDX_W-1:0] h_idx;
    logic [IDX_W-1:0] l_idx;
    logic             l_wr;
    logic             collide;
    logic             l_wr_eff;

    assign h_idx    = {h_bank, h_off};
    assign l_idx    = {l_bank, l_off};
    assign l_wr     = l_en && l_we;
    assign collide  = h_wr && l_wr && (h_idx == l_idx);
    assign l_wr_eff = l_wr && !collide;

    // Host port has priority on a shared cell.
    always_ff @(posedge clk) begin
        if (l_wr_eff)
            mem[l_idx] <= l_wdata;
        if (h_wr)
            mem[h_idx] <= h_wdata;
    end

    // Reads see the contents from before this edge's writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
            l_q <= '0;
        end else begin
            if (h_rd)
                h_q <= mem[h_idx];
            if (l_en && !l_we)
                l_q <= mem[l_idx];
        end
    end
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       h_en,
    input  logic       h_we,
    input  logic [6:0] h_addr,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    input  logic       ld_en,
    input  logic       ld_we,
    input  logic [3:0] ld_bank,
    input  logic [5:0] ld_off,
    input  logic [7:0] ld_wdata,
    output logic [7:0] ld_rdata
);
    acc_t  acc;
    bank_t bank_sel;
    byte_t dir_q;
    byte_t bank_q;
    logic  src_dir_q;
    logic  dir_wr;
    logic  dir_rd;
    logic  bank_wr;
    logic  bank_rd;

    cfgrf_decode u_dec (
        .en       (h_en),
        .we       (h_we),
        .addr     (h_addr),
        .wdata    (h_wdata),
        .bank_sel (bank_sel),
        .acc      (acc)
    );

    assign dir_wr  = (acc.tgt == TGT_DIRECT) &&  acc.wr;
    assign dir_rd  = (acc.tgt == TGT_DIRECT) && !acc.wr;
    assign bank_wr = (acc.tgt == TGT_BANK)   &&  acc.wr;
    assign bank_rd = (acc.tgt == TGT_BANK)   && !acc.wr;

    cfgrf_direct u_dir (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (dir_wr),
        .rd_en    (dir_rd),
        .off      (acc.off),
        .wdata    (acc.wdata),
        .rd_q     (dir_q),
        .bank_sel (bank_sel)
    );

    cfgrf_bank_store u_store (
        .clk     (clk),
        .rst     (rst),
        .h_wr    (bank_wr),
        .h_rd    (bank_rd),
        .h_bank  (acc.bank),
        .h_off   (acc.off),
        .h_wdata (acc.wdata),
        .l_en    (ld_en),
        .l_we    (ld_we),
        .l_bank  (ld_bank),
        .l_off   (ld_off),
        .l_wdata (ld_wdata),
        .h_q     (bank_q),
        .l_q     (ld_rdata)
    );

    // Remember which store answered the last host read.
    always_ff @(posedge clk) begin
        if (rst)
            src_dir_q <= 1'b1;
        else if (dir_rd || bank_rd)
            src_dir_q <= dir_rd;
    end

    assign h_rdata = src_dir_q ? dir_q : bank_q;
endmodule

// File: rtl/cfgrf_checker.sv
module cfgrf_checker (
    input logic       clk,
    input logic       rst,
    input logic       h_en,
    input logic       h_we,
    input logic [6:0] h_addr,
    input logic [7:0] h_wdata,
    input logic [7:0] h_rdata,
    input logic       ld_en,
    input logic       ld_we,
    input logic [7:0] ld_rdata,
    input logic [3:0] bank_sel
);
    logic bsel_wr;
    assign bsel_wr = h_en && h_we && (h_addr == 7'h40);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (h_rdata == 8'h00 && ld_rdata == 8'h00));

    p_host_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!h_en || h_we) |=> $stable(h_rdata));

    p_sel_kept_r3: assert property (@(posedge clk) disable iff (rst)
        !bsel_wr |=> $stable(bank_sel));

    p_sel_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (h_en && !h_we && h_addr == 7'h40) |=> (h_rdata[7:4] == 4'h0));

    p_sel_next_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        bsel_wr |=> (bank_sel == $past(h_wdata[3:0])));

    p_loader_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!ld_en || ld_we) |=> $stable(ld_rdata));
endmodule

bind cfgrf_top cfgrf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .h_en     (h_en),
    .h_we     (h_we),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .h_rdata  (h_rdata),
    .ld_en    (ld_en),
    .ld_we    (ld_we),
    .ld_rdata (ld_rdata),
    .bank_sel (bank_sel)
);

// File: tb/tb_cfgrf_top.sv
`timescale 1ns/1ps
module tb_cfgrf_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_en = 1'b0, h_we = 1'b0;
    logic [6:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       ld_en = 1'b0, ld_we = 1'b0;
    logic [3:0] ld_bank = '0;
    logic [5:0] ld_off = '0;
    logic [7:0] ld_wdata = '0;
    logic [7:0] ld_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    cfgrf_top dut (
        .clk(clk), .rst(rst),
        .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .ld_en(ld_en), .ld_we(ld_we), .ld_bank(ld_bank), .ld_off(ld_off),
        .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         issue;
        bit         is_ld;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];

    // Reference model built from the requirements.
    logic [7:0] mem_ref [16][64];
    logic [7:0] dir_ref [64];
    logic [3:0] bsel_ref;
    logic [7:0] last_h, last_l;

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].issue == cyc - 1) begin
            item_t it;
            it = q.pop_front();
            if (it.is_ld)
                check(it.tag, "ld_rdata", ld_rdata, it.exp);
            else
                check(it.tag, "h_rdata", h_rdata, it.exp);
        end
    end

    task automatic step(string tag,
                        bit he, bit hw, bit [6:0] ha, bit [7:0] hd,
                        bit le, bit lw, bit [3:0] lb, bit [5:0] lo, bit [7:0] ld);
        item_t hi, li;
        h_en = he; h_we = hw; h_addr = ha; h_wdata = hd;
        ld_en = le; ld_we = lw; ld_bank = lb; ld_off = lo; ld_wdata = ld;
        if (he && !hw)
            last_h = ha[6] ? dir_ref[ha[5:0]] : mem_ref[bsel_ref][ha[5:0]];
        if (le && !lw)
            last_l = mem_ref[lb][lo];
        hi.issue = cyc; hi.is_ld = 1'b0; hi.exp = last_h; hi.tag = tag;
        li.issue = cyc; li.is_ld = 1'b1; li.exp = last_l; li.tag = tag;
        q.push_back(hi);
        q.push_back(li);
        if (le && lw)
            mem_ref[lb][lo] = ld;
        if (he && hw) begin
            if (ha[6]) begin
                if (ha[5:0] == 6'd0) begin
                    bsel_ref   = hd[3:0];
                    dir_ref[0] = {4'h0, hd[3:0]};
                end else begin
                    dir_ref[ha[5:0]] = hd;
                end
            end else begin
                mem_ref[bsel_ref][ha[5:0]] = hd;
            end
        end
        @(negedge clk);
    endtask

    task automatic hwr(string tag, bit [6:0] a, bit [7:0] d);
        step(tag, 1, 1, a, d, 0, 0, 0, 0, 0);
    endtask
    task automatic hrd(string tag, bit [6:0] a);
        step(tag, 1, 0, a, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic lwr(string tag, bit [3:0] b, bit [5:0] o, bit [7:0] d);
        step(tag, 0, 0, 0, 0, 1, 1, b, o, d);
    endtask
    task automatic lrd(string tag, bit [3:0] b, bit [5:0] o);
        step(tag, 0, 0, 0, 0, 1, 0, b, o, 0);
    endtask
    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dir_ref[i] = 8'h00;
        for (int b = 0; b < 16; b++)
            for (int i = 0; i < 64; i++) mem_ref[b][i] = 8'h00;
        bsel_ref = 4'h0; last_h = 8'h00; last_l = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "h_rdata after reset", h_rdata, 8'h00);
        check("R1", "ld_rdata after reset", ld_rdata, 8'h00);
        hrd("R1", 7'h40);
        hrd("R1", 7'h55);
        // R3 direct registers
        hwr("R3", 7'h41, 8'hA5);
        hwr("R3", 7'h7F, 8'h3C);
        hrd("R3", 7'h41);
        hrd("R3", 7'h7F);
        // R5 windowing, bank 0 then bank 3
        hwr("R5", 7'h05, 8'h11);
        hwr("R5", 7'h3F, 8'h22);
        hwr("R5", 7'h40, 8'h03);
        hwr("R5", 7'h05, 8'h33);
        hrd("R5", 7'h05);
        // R6 access right after select write
        hwr("R6", 7'h40, 8'h00);
        hrd("R6", 7'h05);
        hrd("R6", 7'h3F);
        hwr("R6", 7'h40, 8'h03);
        hrd("R6", 7'h05);
        // R4 sanitized select
        hwr("R4", 7'h40, 8'hF7);
        hrd("R4", 7'h40);
        hwr("R4", 7'h40, 8'h3A);
        hrd("R4", 7'h40);
        hrd("R3", 7'h41);
        // R7 loader independent of selection
        lwr("R7", 4'h9, 6'h10, 8'h99);
        lrd("R7", 4'h0, 6'h05);
        lrd("R7", 4'h3, 6'h05);
        hwr("R7", 7'h40, 8'h09);
        hrd("R7", 7'h10);
        // R8 / R2 hold across idle cycles
        idle("R8");
        idle("R2");
        hwr("R2", 7'h42, 8'h77);
        lwr("R8", 4'hF, 6'h3F, 8'hE1);
        lrd("R8", 4'hF, 6'h3F);
        // R9 collision: host wins; distinct cells both land
        step("R9", 1, 1, 7'h20, 8'hAA, 1, 1, 4'h9, 6'h20, 8'hBB);
        hrd("R9", 7'h20);
        lrd("R9", 4'h9, 6'h20);
        step("R9", 1, 1, 7'h22, 8'h12, 1, 1, 4'h9, 6'h23, 8'h34);
        hrd("R9", 7'h22);
        hrd("R9", 7'h23);
        // R10 loader read-before-write
        lwr("R10", 4'h9, 6'h21, 8'h42);
        step("R10", 1, 1, 7'h21, 8'h5C, 1, 0, 4'h9, 6'h21, 8'h00);
        lrd("R10", 4'h9, 6'h21);
        hrd("R10", 7'h21);
        // R3 loader does not reach direct area; R5 other bank untouched
        hrd("R3", 7'h42);
        hwr("R5", 7'h40, 8'h00);
        hrd("R5", 7'h05);
        idle("R2");
        idle("R2");
        done = 1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule